// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer with a 32-bit register interface. A 32-bit counter runs upward from a load value. It advances on a slow timer tick that can be divided by a power of two. When the counter passes its all-ones value, the block records an overflow event, reloads the counter and drives a system reset request for a fixed number of bus clocks. A delay event marks the moment the counter reaches a programmed compare value. Either event can raise the interrupt line.

Software must take two deliberate steps to stop or start the counter. It writes an ordered pair of key values to the start/stop register, and the second key must be the next write to that register. Writes to the control, counter, load, trigger, start/stop and delay registers do not take effect at once. Each of them waits for a fixed number of timer ticks. While a write waits, a per-register pending bit is set, and software polls that bit before it writes the same register again. A write to the trigger register reloads the counter from the load register, but only when the written value differs from the value the trigger register already holds.

The timer clock enters as a one-cycle strobe `tick_i`, which is synchronous to the bus clock. Every register therefore lives in one clock domain, and the posting latency is counted in ticks.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the registers read as follows. ID (0x00) gives the ID_VALUE parameter. Control (0x24) gives 0x20. Counter (0x28) and load (0x2C) both give LOAD_RST. Trigger, delay, key, pending (0x34), enable (0x5C/0x60) and events (0x54/0x58) all give 0. The counter is running, and `irq_o` and `wdt_rst_o` are low.
- R2: While running, the counter increases by one on every counter tick. While stopped, it holds its value.
- R3: The counter stops when 0xAAAA takes effect and 0x5555 takes effect as the next start/stop (0x48) write. It starts when 0xBBBB takes effect and 0x4444 takes effect as the next write. Any other value between the two keys cancels the sequence.
- R4: An accepted write to a posted register sets its bit in the pending register (0x34). The bits are control 0, counter 1, load 2, trigger 3, start/stop 4 and delay 5. The bit clears, and the value takes effect, on the SYNC_TICKS-th tick after the write. A write to a register whose pending bit is set is discarded.
- R5: When a trigger (0x30) write takes effect with a value that differs from the trigger register, the counter reloads from the load register. When the value is equal, the counter is unchanged. The trigger register reads back the last value that took effect.
- R6: A counter tick at 0xFFFFFFFF reloads the counter from the load register and sets overflow event bit 0. It also holds `wdt_rst_o` high for exactly RST_PULSE bus clocks.
- R7: When the counter advances onto the value in the delay register (0x44), delay event bit 1 is set.
- R8: The raw register (0x54) shows the events whether or not they are enabled. The status register (0x58) shows events AND enable. Writing a 1 to 0x5C sets that enable bit, and writing a 1 to 0x60 clears it. Writing a 1 to 0x58 clears that event. `irq_o` is the OR of the enabled events.
- R9: When an event is set and cleared in the same cycle, the set wins.
- R10: Control bit 5 enables the prescaler, and bits 4:2 hold the divide exponent k. With the prescaler enabled, the counter advances once every 2^k ticks. The first advance comes on the 2^k-th tick after the control write takes effect. With the prescaler disabled, the counter advances on every tick.
- R11: Writing bit 1 of system control (0x10) makes that bit read 1 for one cycle. After that, every register, pending bit and event returns to its R1 value and the bit reads 0.
- R12: A write to the counter register (0x28) loads the counter directly once it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle timer tick strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt request |
| wdt_rst_o | output | 1 | Reset request pulse on overflow |

## Verification
The overflow event capture and the software clear of that event can land in the same bus cycle. The bench steers the counter to 0xFFFFFFFF with a counter write. It then drives a write of 1 to the status register together with the tick that causes the wrap. The raw register must still show the overflow bit afterwards, and the counter must hold the load value. A design in which the clear wins, or in which the commit and count paths are ordered wrongly, fails that read.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int NUM_POST = 6;
    localparam int PTV_W    = 3;
    localparam int PRESC_W  = (1 << PTV_W) - 1;
    localparam int EVT_W    = 2;

    // Pending-bit positions of posted registers (software decodes these)
    localparam int POST_CTRL = 0;
    localparam int POST_CNT  = 1;
    localparam int POST_LOAD = 2;
    localparam int POST_TRIG = 3;
    localparam int POST_KEY  = 4;
    localparam int POST_DLY  = 5;

    // Event bit positions
    localparam int EVT_OVF = 0;
    localparam int EVT_DLY = 1;

    // Register map
    localparam logic [ADDR_W-1:0] OFS_ID    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SYS   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CNT   = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_PEND  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_DLY   = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_KEY   = 8'h48;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h54;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h58;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h5C;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h60;

    localparam int SYS_SRST_BIT = 1;

    // Key values
    localparam logic [DATA_W-1:0] KEY_STOP_A  = 32'h0000_AAAA;
    localparam logic [DATA_W-1:0] KEY_STOP_B  = 32'h0000_5555;
    localparam logic [DATA_W-1:0] KEY_START_A = 32'h0000_BBBB;
    localparam logic [DATA_W-1:0] KEY_START_B = 32'h0000_4444;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_STOP1  = 2'd1,
        KS_START1 = 2'd2
    } key_st_e;

    typedef struct packed {
        logic             pre_en;
        logic [PTV_W-1:0] ptv;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{pre_en: 1'b1, ptv: '0};

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.pre_en = w[2+PTV_W];
        c.ptv    = w[2 +: PTV_W];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_to_word(input ctrl_t c);
        return DATA_W'({c.pre_en, c.ptv, 2'b00});
    endfunction

    function automatic logic [PRESC_W-1:0] presc_mask(input logic [PTV_W-1:0] ptv);
        return PRESC_W'((1 << ptv) - 1);
    endfunction

    function automatic logic [ADDR_W-1:0] post_ofs(input int idx);
        case (idx)
            POST_CTRL: return OFS_CTRL;
            POST_CNT:  return OFS_CNT;
            POST_LOAD: return OFS_LOAD;
            POST_TRIG: return OFS_TRIG;
            POST_KEY:  return OFS_KEY;
            default:   return OFS_DLY;
        endcase
    endfunction

endpackage

// File: rtl/kwdt_post_slot.sv
// One posted register: captures a bus write, holds it for SYNC_TICKS ticks,
// then issues a one-cycle commit strobe alongside the held data.
module kwdt_post_slot #(
    parameter int SYNC_TICKS = 3,
    parameter int DW         = 32
) (
    input  logic          clk_i,
    input  logic          clr_i,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic          pend_o,
    output logic [DW-1:0] data_o,
    output logic          commit_o
);
    localparam int CW = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(SYNC_TICKS - 1);

    logic          pend_q;
    logic [DW-1:0] data_q;
    logic [CW-1:0] cnt_q;

    assign commit_o = pend_q && tick_i && (cnt_q == LAST);
    assign pend_o   = pend_q;
    assign data_o   = data_q;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            pend_q <= 1'b0;
            data_q <= '0;
            cnt_q  <= '0;
        end else if (!pend_q) begin
            if (wr_i) begin
                pend_q <= 1'b1;
                data_q <= wdata_i;
                cnt_q  <= '0;
            end
        end else if (tick_i) begin
            if (cnt_q == LAST) pend_q <= 1'b0;
            else               cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R4: a pending write survives until a tick arrives
    assert_pend_hold_R4: assert property (@(posedge clk_i) disable iff (clr_i)
        (pend_q && !tick_i) |=> pend_q);
    // R4: a second write while pending leaves the held value alone
    assert_pend_ignore_R4: assert property (@(posedge clk_i) disable iff (clr_i)
        (pend_q && wr_i) |=> $stable(data_q));

endmodule

// File: rtl/kwdt_key_fsm.sv
// Two-key start/stop sequencer, fed by committed start/stop writes.
module kwdt_key_fsm
    import kwdt_pkg::*;
(
    input  logic              clk_i,
    input  logic              clr_i,
    input  logic              commit_i,
    input  logic [DATA_W-1:0] key_i,
    output logic              run_o,
    output logic [DATA_W-1:0] key_o
);
    key_st_e           st_q;
    logic              run_q;
    logic [DATA_W-1:0] key_q;

    assign run_o = run_q;
    assign key_o = key_q;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            st_q  <= KS_IDLE;
            run_q <= 1'b1;
            key_q <= '0;
        end else if (commit_i) begin
            key_q <= key_i;
            if (st_q == KS_STOP1 && key_i == KEY_STOP_B) begin
                run_q <= 1'b0;
                st_q  <= KS_IDLE;
            end else if (st_q == KS_START1 && key_i == KEY_START_B) begin
                run_q <= 1'b1;
                st_q  <= KS_IDLE;
            end else if (key_i == KEY_STOP_A) begin
                st_q <= KS_STOP1;
            end else if (key_i == KEY_START_A) begin
                st_q <= KS_START1;
            end else begin
                st_q <= KS_IDLE;
            end
        end
    end

    // R3: the completed stop pair halts the counter
    assert_stop_pair_R3: assert property (@(posedge clk_i) disable iff (clr_i)
        (commit_i && st_q == KS_STOP1 && key_i == KEY_STOP_B) |=> !run_q);
    // R3: run state only moves on a committed key write
    assert_run_needs_key_R3: assert property (@(posedge clk_i) disable iff (clr_i)
        !commit_i |=> $stable(run_q));

endmodule

// File: rtl/kwdt_core.sv
// Timer-side state: prescaler, counter, load/trigger/delay registers,
// event generation and the reset pulse stretcher.
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter logic [DATA_W-1:0] LOAD_RST  = 32'hFFFD_0000,
    parameter int                RST_PULSE = 16
) (
    input  logic              clk_i,
    input  logic              clr_i,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              ctrl_cmt_i,
    input  logic              cnt_cmt_i,
    input  logic              load_cmt_i,
    input  logic              trig_cmt_i,
    input  logic              dly_cmt_i,
    input  logic [DATA_W-1:0] ctrl_data_i,
    input  logic [DATA_W-1:0] cnt_data_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic [DATA_W-1:0] trig_data_i,
    input  logic [DATA_W-1:0] dly_data_i,
    output logic [DATA_W-1:0] count_o,
    output logic [DATA_W-1:0] load_o,
    output logic [DATA_W-1:0] trig_o,
    output logic [DATA_W-1:0] dly_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic              ovf_o,
    output logic              dly_evt_o,
    output logic              wdt_rst_o
);
    localparam int RW = $clog2(RST_PULSE + 1);

    ctrl_t              ctrl_q;
    logic [PRESC_W-1:0] presc_q;
    logic [DATA_W-1:0]  count_q, load_q, trig_q, dly_q;
    logic [RW-1:0]      rst_cnt_q;

    logic               cnt_tick, adv, trig_fire, override, wrap;
    logic [PRESC_W-1:0] mask;
    logic [DATA_W-1:0]  count_inc;

    always_comb begin
        mask      = presc_mask(ctrl_q.ptv);
        cnt_tick  = tick_i && (!ctrl_q.pre_en || ((presc_q & mask) == mask));
        adv       = cnt_tick && run_i;
        trig_fire = trig_cmt_i && (trig_data_i != trig_q);
        override  = cnt_cmt_i || trig_fire;
        wrap      = adv && (count_q == '1);
        count_inc = count_q + DATA_W'(1);
    end

    assign ovf_o     = wrap && !override;
    assign dly_evt_o = adv && !wrap && !override && (count_inc == dly_q);
    assign wdt_rst_o = (rst_cnt_q != '0);

    assign count_o = count_q;
    assign load_o  = load_q;
    assign trig_o  = trig_q;
    assign dly_o   = dly_q;
    assign ctrl_o  = ctrl_to_word(ctrl_q);

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            ctrl_q    <= CTRL_RST;
            presc_q   <= '0;
            count_q   <= LOAD_RST;
            load_q    <= LOAD_RST;
            trig_q    <= '0;
            dly_q     <= '0;
            rst_cnt_q <= '0;
        end else begin
            if (ctrl_cmt_i) begin
                ctrl_q  <= ctrl_from_word(ctrl_data_i);
                presc_q <= '0;
            end else if (tick_i) begin
                presc_q <= presc_q + 1'b1;
            end

            if (load_cmt_i) load_q <= load_data_i;
            if (dly_cmt_i)  dly_q  <= dly_data_i;
            if (trig_cmt_i) trig_q <= trig_data_i;

            if (cnt_cmt_i)      count_q <= cnt_data_i;
            else if (trig_fire) count_q <= load_q;
            else if (wrap)      count_q <= load_q;
            else if (adv)       count_q <= count_inc;

            if (ovf_o)                  rst_cnt_q <= RW'(RST_PULSE);
            else if (rst_cnt_q != '0)   rst_cnt_q <= rst_cnt_q - 1'b1;
        end
    end

    // R2: a stopped counter with no committed write holds its value
    assert_stopped_hold_R2: assert property (@(posedge clk_i) disable iff (clr_i)
        (!run_i && !cnt_cmt_i && !trig_cmt_i) |=> $stable(count_q));
    // R6: overflow reloads the counter from the previous load value
    assert_ovf_reload_R6: assert property (@(posedge clk_i) disable iff (clr_i)
        ovf_o |=> (count_q == $past(load_q)));
    // R6: overflow raises the reset request on the next cycle
    assert_ovf_rst_R6: assert property (@(posedge clk_i) disable iff (clr_i)
        ovf_o |=> wdt_rst_o);
    // R7: a delay event leaves the counter on the delay value
    assert_dly_match_R7: assert property (@(posedge clk_i) disable iff (clr_i)
        dly_evt_o |=> (count_q == $past(dly_q)));

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int                SYNC_TICKS = 3,
    parameter logic [DATA_W-1:0] LOAD_RST   = 32'hFFFD_0000,
    parameter int                RST_PULSE  = 16,
    parameter logic [DATA_W-1:0] ID_VALUE   = 32'h0057_4401
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    logic clr;
    logic srst_q;

    logic [NUM_POST-1:0] post_wr, post_pend, post_cmt;
    logic [DATA_W-1:0]   post_data [NUM_POST];

    logic              run;
    logic [DATA_W-1:0] key_q, count, load, trig, dly, ctrl_word;
    logic              ovf, dly_evt;

    logic [EVT_W-1:0] evt_q, en_q, evt_set, evt_w1c;

    assign clr = rst_i || srst_q;

    generate
        for (genvar i = 0; i < NUM_POST; i++) begin : g_post
            assign post_wr[i] = bus_we_i && (bus_addr_i == post_ofs(i));
            kwdt_post_slot #(
                .SYNC_TICKS(SYNC_TICKS),
                .DW        (DATA_W)
            ) slot_i (
                .clk_i   (clk_i),
                .clr_i   (clr),
                .tick_i  (tick_i),
                .wr_i    (post_wr[i]),
                .wdata_i (bus_wdata_i),
                .pend_o  (post_pend[i]),
                .data_o  (post_data[i]),
                .commit_o(post_cmt[i])
            );
        end
    endgenerate

    kwdt_key_fsm key_i (
        .clk_i   (clk_i),
        .clr_i   (clr),
        .commit_i(post_cmt[POST_KEY]),
        .key_i   (post_data[POST_KEY]),
        .run_o   (run),
        .key_o   (key_q)
    );

    kwdt_core #(
        .LOAD_RST (LOAD_RST),
        .RST_PULSE(RST_PULSE)
    ) core_i (
        .clk_i      (clk_i),
        .clr_i      (clr),
        .tick_i     (tick_i),
        .run_i      (run),
        .ctrl_cmt_i (post_cmt[POST_CTRL]),
        .cnt_cmt_i  (post_cmt[POST_CNT]),
        .load_cmt_i (post_cmt[POST_LOAD]),
        .trig_cmt_i (post_cmt[POST_TRIG]),
        .dly_cmt_i  (post_cmt[POST_DLY]),
        .ctrl_data_i(post_data[POST_CTRL]),
        .cnt_data_i (post_data[POST_CNT]),
        .load_data_i(post_data[POST_LOAD]),
        .trig_data_i(post_data[POST_TRIG]),
        .dly_data_i (post_data[POST_DLY]),
        .count_o    (count),
        .load_o     (load),
        .trig_o     (trig),
        .dly_o      (dly),
        .ctrl_o     (ctrl_word),
        .ovf_o      (ovf),
        .dly_evt_o  (dly_evt),
        .wdt_rst_o  (wdt_rst_o)
    );

    // Event capture: set has priority over write-one-to-clear
    always_comb begin
        evt_set          = '0;
        evt_set[EVT_OVF] = ovf;
        evt_set[EVT_DLY] = dly_evt;
        evt_w1c = (bus_we_i && bus_addr_i == OFS_STAT) ? bus_wdata_i[EVT_W-1:0] : '0;
    end

    always_ff @(posedge clk_i) begin
        if (clr) begin
            evt_q <= '0;
            en_q  <= '0;
        end else begin
            evt_q <= (evt_q & ~evt_w1c) | evt_set;
            if (bus_we_i && bus_addr_i == OFS_ENSET)
                en_q <= en_q | bus_wdata_i[EVT_W-1:0];
            else if (bus_we_i && bus_addr_i == OFS_ENCLR)
                en_q <= en_q & ~bus_wdata_i[EVT_W-1:0];
        end
    end

    // Soft reset: visible for one cycle, then clears everything including itself
    always_ff @(posedge clk_i) begin
        if (clr) srst_q <= 1'b0;
        else     srst_q <= bus_we_i && (bus_addr_i == OFS_SYS) && bus_wdata_i[SYS_SRST_BIT];
    end

    assign irq_o = |(evt_q & en_q);

    always_comb begin
        case (bus_addr_i)
            OFS_ID:    bus_rdata_o = ID_VALUE;
            OFS_SYS:   bus_rdata_o = DATA_W'({srst_q, 1'b0});
            OFS_CTRL:  bus_rdata_o = ctrl_word;
            OFS_CNT:   bus_rdata_o = count;
            OFS_LOAD:  bus_rdata_o = load;
            OFS_TRIG:  bus_rdata_o = trig;
            OFS_PEND:  bus_rdata_o = DATA_W'(post_pend);
            OFS_DLY:   bus_rdata_o = dly;
            OFS_KEY:   bus_rdata_o = key_q;
            OFS_RAW:   bus_rdata_o = DATA_W'(evt_q);
            OFS_STAT:  bus_rdata_o = DATA_W'(evt_q & en_q);
            OFS_ENSET: bus_rdata_o = DATA_W'(en_q);
            OFS_ENCLR: bus_rdata_o = DATA_W'(en_q);
            default:   bus_rdata_o = '0;
        endcase
    end

    // R9: an overflow is captured even when cleared in the same cycle
    assert_set_wins_R9: assert property (@(posedge clk_i) disable iff (clr)
        ovf |=> evt_q[EVT_OVF]);
    // R8: a clear with no new event removes the overflow bit
    assert_w1c_R8: assert property (@(posedge clk_i) disable iff (clr)
        (bus_we_i && bus_addr_i == OFS_STAT && bus_wdata_i[EVT_OVF] && !ovf)
        |=> !evt_q[EVT_OVF]);
    // R11: the soft-reset flag lasts a single cycle
    assert_srst_once_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        srst_q |=> !srst_q);

endmodule

// File: tb/keyed_wdt_tb_top.sv
`timescale 1ns/1ps
module keyed_wdt_tb_top;

    localparam logic [31:0] TB_LOAD = 32'hFFFF_FFF0;
    localparam logic [31:0] TB_ID   = 32'h5744_0001;
    localparam int          TB_SYNC = 3;
    localparam int          TB_RSTP = 4;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_TK = 2'd2;
    localparam logic [1:0] OP_PN = 2'd3;  // addr 0: irq_o, addr 1: wdt_rst_o

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 92;
    localparam vec_t VEC [NV] = '{
        // R1 reset state
        '{OP_RD, 4'd1, 8'h00, 32'h0, TB_ID},
        '{OP_RD, 4'd1, 8'h28, 32'h0, TB_LOAD},
        '{OP_RD, 4'd1, 8'h2C, 32'h0, TB_LOAD},
        '{OP_RD, 4'd1, 8'h24, 32'h0, 32'h20},
        '{OP_RD, 4'd1, 8'h34, 32'h0, 32'h0},
        '{OP_RD, 4'd1, 8'h5C, 32'h0, 32'h0},
        '{OP_PN, 4'd1, 8'h00, 32'h0, 32'h0},
        '{OP_PN, 4'd1, 8'h01, 32'h0, 32'h0},
        // R2 running from reset
        '{OP_TK, 4'd2, 8'h00, 32'd4, 32'h0},
        '{OP_RD, 4'd2, 8'h28, 32'h0, 32'hFFFF_FFF4},
        // R4 pending bit 4, R3 stop pair
        '{OP_WR, 4'd4, 8'h48, 32'hAAAA, 32'h0},
        '{OP_RD, 4'd4, 8'h34, 32'h0, 32'h10},
        '{OP_TK, 4'd4, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd4, 8'h34, 32'h0, 32'h0},
        '{OP_WR, 4'd3, 8'h48, 32'h5555, 32'h0},
        '{OP_TK, 4'd3, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd3, 8'h28, 32'h0, 32'hFFFF_FFFA},
        '{OP_TK, 4'd2, 8'h00, 32'd5, 32'h0},
        '{OP_RD, 4'd2, 8'h28, 32'h0, 32'hFFFF_FFFA},
        // R4 write while pending is discarded, pending bit 2
        '{OP_WR, 4'd4, 8'h2C, 32'hFFFF_FF00, 32'h0},
        '{OP_WR, 4'd4, 8'h2C, 32'h1234_5678, 32'h0},
        '{OP_RD, 4'd4, 8'h34, 32'h0, 32'h04},
        '{OP_TK, 4'd4, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd4, 8'h2C, 32'h0, 32'hFFFF_FF00},
        '{OP_RD, 4'd2, 8'h28, 32'h0, 32'hFFFF_FFFA},
        // R5 trigger with a new value reloads
        '{OP_WR, 4'd5, 8'h30, 32'h1, 32'h0},
        '{OP_TK, 4'd5, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd5, 8'h28, 32'h0, 32'hFFFF_FF00},
        '{OP_RD, 4'd5, 8'h30, 32'h0, 32'h1},
        // R12 direct counter write
        '{OP_WR, 4'd12, 8'h28, 32'h50, 32'h0},
        '{OP_TK, 4'd12, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd12, 8'h28, 32'h0, 32'h50},
        // R5 trigger with the same value has no effect
        '{OP_WR, 4'd5, 8'h30, 32'h1, 32'h0},
        '{OP_TK, 4'd5, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd5, 8'h28, 32'h0, 32'h50},
        // R3 start pair
        '{OP_WR, 4'd3, 8'h48, 32'hBBBB, 32'h0},
        '{OP_TK, 4'd3, 8'h00, 32'd3, 32'h0},
        '{OP_WR, 4'd3, 8'h48, 32'h4444, 32'h0},
        '{OP_TK, 4'd3, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd3, 8'h28, 32'h0, 32'h50},
        '{OP_TK, 4'd3, 8'h00, 32'd2, 32'h0},
        '{OP_RD, 4'd3, 8'h28, 32'h0, 32'h52},
        // R3 cancelled stop sequence: counter keeps running
        '{OP_WR, 4'd3, 8'h48, 32'hAAAA, 32'h0},
        '{OP_TK, 4'd3, 8'h00, 32'd3, 32'h0},
        '{OP_WR, 4'd3, 8'h48, 32'h1234, 32'h0},
        '{OP_TK, 4'd3, 8'h00, 32'd3, 32'h0},
        '{OP_WR, 4'd3, 8'h48, 32'h5555, 32'h0},
        '{OP_TK, 4'd3, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd3, 8'h28, 32'h0, 32'h5B},
        // R10 prescaler k=2 (ctrl 0x28)
        '{OP_WR, 4'd10, 8'h24, 32'h28, 32'h0},
        '{OP_TK, 4'd10, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd10, 8'h28, 32'h0, 32'h5E},
        '{OP_TK, 4'd10, 8'h00, 32'd3, 32'h0},
        '{OP_RD, 4'd10, 8'h28, 32'h0, 32'h5E},
        '{OP_TK, 4'd10, 8'h00, 32'd1, 32'h0},
        '{OP_RD, 4'd10, 8'h28, 32'h0, 32'h5F},
        // R10 prescaler disabled (ctrl 0x08)
        '{OP_WR, 4'd10, 8'h24, 32'h08, 32'h0},
        '{OP_TK, 4'd10, 8'h00, 32'd3, 32'h0},
        '{OP_TK, 4'd10, 8'h00, 32'd2, 32'h0},
        '{OP_RD, 4'd10, 8'h28, 32'h0, 32'h61},
        '{OP_RD, 4'd10, 8'h24, 32'h0, 32'h08},
        // R8 enables
        '{OP_WR, 4'd8, 8'h5C, 32'h3, 32'h0},
        '{OP_RD, 4'd8, 8'h5C, 32'h0, 32'h3},
        // R7 delay event
        '{OP_WR, 4'd7, 8'h44, 32'hFFFF_FFF8, 32'h0},
        '{OP_TK, 4'd7, 8'h00, 32'd3, 32'h0},
        '{OP_WR, 4'd12, 8'h28, 32'hFFFF_FFF0, 32'h0},
        '{OP_TK, 4'd12, 8'h00, 32'd3, 32'h0},
        '{OP_TK, 4'd7, 8'h00, 32'd7, 32'h0},
        '{OP_RD, 4'd7, 8'h54, 32'h0, 32'h0},
        '{OP_TK, 4'd7, 8'h00, 32'd1, 32'h0},
        '{OP_RD, 4'd7, 8'h54, 32'h0, 32'h2},
        '{OP_RD, 4'd8, 8'h58, 32'h0, 32'h2},
        '{OP_PN, 4'd8, 8'h00, 32'h0, 32'h1},
        '{OP_WR, 4'd8, 8'h58, 32'h2, 32'h0},
        '{OP_RD, 4'd8, 8'h54, 32'h0, 32'h0},
        '{OP_PN, 4'd8, 8'h00, 32'h0, 32'h0},
        // R6 overflow and reset pulse of 4 clocks
        '{OP_TK, 4'd6, 8'h00, 32'd7, 32'h0},
        '{OP_PN, 4'd6, 8'h01, 32'h0, 32'h0},
        '{OP_TK, 4'd6, 8'h00, 32'd1, 32'h0},
        '{OP_PN, 4'd6, 8'h01, 32'h0, 32'h1},
        '{OP_RD, 4'd6, 8'h28, 32'h0, 32'hFFFF_FF00},
        '{OP_RD, 4'd6, 8'h54, 32'h0, 32'h1},
        '{OP_PN, 4'd6, 8'h01, 32'h0, 32'h1},
        '{OP_PN, 4'd6, 8'h01, 32'h0, 32'h0},
        // R8 masking by enable
        '{OP_PN, 4'd8, 8'h00, 32'h0, 32'h1},
        '{OP_WR, 4'd8, 8'h60, 32'h1, 32'h0},
        '{OP_PN, 4'd8, 8'h00, 32'h0, 32'h0},
        '{OP_RD, 4'd8, 8'h54, 32'h0, 32'h1},
        '{OP_RD, 4'd8, 8'h58, 32'h0, 32'h0},
        '{OP_RD, 4'd8, 8'h5C, 32'h0, 32'h2},
        '{OP_WR, 4'd8, 8'h58, 32'h1, 32'h0},
        '{OP_RD, 4'd8, 8'h54, 32'h0, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, wrst;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    keyed_wdt #(
        .SYNC_TICKS(TB_SYNC),
        .LOAD_RST  (TB_LOAD),
        .RST_PULSE (TB_RSTP),
        .ID_VALUE  (TB_ID)
    ) dut_i (
        .clk_i      (clk),
        .rst_i      (rst),
        .tick_i     (tick),
        .bus_we_i   (we),
        .bus_addr_i (addr),
        .bus_wdata_i(wdata),
        .bus_rdata_o(rdata),
        .irq_o      (irq),
        .wdt_rst_o  (wrst)
    );

    task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic do_rd(input int req, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
        @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic do_pin(input int req, input logic [7:0] sel, input logic [31:0] exp);
        #1;
        check(req, (sel == 8'h00) ? {31'b0, irq} : {31'b0, wrst}, exp);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R0 watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_WR:   do_wr(VEC[i].addr, VEC[i].data);
                OP_RD:   do_rd(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
                OP_TK:   do_ticks(int'(VEC[i].data));
                default: do_pin(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
            endcase
        end

        // R9: overflow and software clear of that event in the same cycle
        do_wr(8'h28, 32'hFFFF_FFFE);
        do_ticks(TB_SYNC);
        do_ticks(1);
        do_rd(12, 8'h28, 32'hFFFF_FFFF);
        we = 1'b1; addr = 8'h58; wdata = 32'h1; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
        do_rd(9, 8'h54, 32'h1);
        do_rd(9, 8'h28, 32'hFFFF_FF00);

        // R11: soft reset with a write still pending
        do_wr(8'h2C, 32'h0000_0777);
        do_wr(8'h10, 32'h2);
        do_rd(11, 8'h10, 32'h2);
        do_rd(11, 8'h10, 32'h0);
        do_rd(11, 8'h34, 32'h0);
        do_rd(11, 8'h2C, TB_LOAD);
        do_rd(11, 8'h28, TB_LOAD);
        do_rd(11, 8'h54, 32'h0);
        do_rd(11, 8'h5C, 32'h0);
        do_rd(11, 8'h24, 32'h20);
        do_rd(11, 8'h30, 32'h0);
        do_ticks(2);
        do_rd(11, 8'h28, TB_LOAD + 32'd2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule